// File: doc/BRIEF.md
# Mezzanine Carrier Local-Window Decoder

This block sits between a host bus and the four module slots of a mezzanine carrier. Each host request names one of three local windows and carries an address, an access size (byte or halfword), a direction and write data. The block splits the address into a slot number and an offset, and picks a sub-space for the target slot. In the small register window that sub-space is I/O, ID or interrupt. In the two memory windows it is memory. It then raises a strobe toward the slot in the same cycle as the request.

Each of the two 16-bit windows has its own big-endian mode bit. In that mode a byte access flips address bit 0 before decoding, and a halfword access swaps the two data bytes on the way in and on the way out. The 8-bit memory window takes byte accesses only and never applies endian correction. A slot with no module fitted never sees a strobe, and a read aimed at it returns zero. Read data comes back one cycle after the request, with the lane correction chosen from the mode bits as they stood in the request cycle.

Top module: `carrier_win_decode`

## Requirements
- R1: `req_win` selects the window: 0 is the 1 KiB register window, 1 is the 16-bit memory window and 2 is the 8-bit memory window. A request with code 3 raises no strobe, and if it is a read it returns zero.
- R2: In window 0 the slot is taken from effective address bits [9:8]. Bits [7:6] give `mod_space` as follows: a value of 2 gives 1 (ID), a value of 3 gives 2 (INT), and 0 or 1 give 0 (I/O). Code 3 on `mod_space` marks a memory access.
- R3: In window 0 the offset keeps effective address bits [6:0] for I/O space and bits [5:0] for ID and INT space. All higher offset bits are zero.
- R4: In window 1 the slot is effective address bits [MEM16_OFS_W+1:MEM16_OFS_W] and the offset is the low MEM16_OFS_W bits.
- R5: In window 2 the slot is address bits [MEM8_OFS_W+1:MEM8_OFS_W] and the offset is the low MEM8_OFS_W bits. Endian mode is never applied there. A halfword request to this window raises no strobe, and if it is a read it returns zero.
- R6: When `be_mode[w]` is 1 for window 0 or 1, a byte access inverts address bit 0 before the slot, sub-space and offset are derived.
- R7: When `be_mode[w]` is 1 for window 0 or 1, a halfword write presents `mod_wdata` with its bytes swapped, and a halfword read returns `mod_rdata` with its bytes swapped. In all other cases the data passes through unchanged.
- R8: When `slot_present` is 0 for the decoded slot, no strobe is raised and a read returns zero.
- R9: `mod_stb`, `mod_slot`, `mod_space` and `mod_ofs` are valid in the request cycle. A read request gives a one-cycle `rsp_valid` pulse in the following cycle, and `rsp_rdata` holds the result in that cycle.
- R10: `rsp_rdata` depends only on `be_mode` as it was in the request cycle. A change to `be_mode` during the response cycle does not alter it.
- R11: A byte read returns `mod_rdata[7:0]` in the low byte of `rsp_rdata`, with the high byte zero.
- R12: While reset is asserted and after it is released, `rsp_valid` and `rsp_rdata` are zero until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_win | input | 2 | Window code (0 registers, 1 mem16, 2 mem8, 3 none) |
| req_addr | input | ADDR_W | Byte address within the window |
| req_size | input | 1 | 0 for a byte access, 1 for a halfword access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 16 | Host write data |
| be_mode | input | 3 | Big-endian mode, one bit per window |
| slot_present | input | 4 | Module fitted, one bit per slot |
| mod_rdata | input | 16 | Read data returned by the addressed slot |
| mod_stb | output | 1 | Access strobe to the slot |
| mod_write | output | 1 | Direction of the strobed access |
| mod_slot | output | 2 | Selected slot |
| mod_space | output | 2 | Sub-space: 0 I/O, 1 ID, 2 INT, 3 memory |
| mod_ofs | output | OFS_W | Offset within the sub-space |
| mod_wdata | output | 16 | Lane-corrected write data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 16 | Lane-corrected read data |

## Verification
The bench builds the block with MEM16_OFS_W = 4 and MEM8_OFS_W = 3. This shrinks the two memory windows to 64 and 32 addresses. The full 1 KiB register window, both memory windows and the reserved window code can then be swept at every address, both sizes, both directions and all eight endian-mode combinations, with one slot left empty. It is this small build that puts every slot boundary, every bit-0 flip and every sub-space edge within reach. During each response cycle the bench also inverts the mode bits, to show that a read already in flight keeps its lane correction.

// File: rtl/carrier_win_decode.sv
module carrier_win_decode #(
  parameter  int MEM16_OFS_W = 23,
  parameter  int MEM8_OFS_W  = 22,
  localparam int A16    = MEM16_OFS_W + 2,
  localparam int A8     = MEM8_OFS_W + 2,
  localparam int A_HI   = (A16 > A8) ? A16 : A8,
  localparam int ADDR_W = (A_HI > 10) ? A_HI : 10,
  localparam int O_HI   = (MEM16_OFS_W > MEM8_OFS_W) ? MEM16_OFS_W : MEM8_OFS_W,
  localparam int OFS_W  = (O_HI > 7) ? O_HI : 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_win,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_size,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  logic [2:0]        be_mode,
  input  logic [3:0]        slot_present,
  input  logic [15:0]       mod_rdata,
  output logic              mod_stb,
  output logic              mod_write,
  output logic [1:0]        mod_slot,
  output logic [1:0]        mod_space,
  output logic [OFS_W-1:0]  mod_ofs,
  output logic [15:0]       mod_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata
);

  logic              swap_en;
  logic              legal;
  logic [ADDR_W-1:0] eff;
  logic [15:0]       rd_next;

  assign swap_en = (req_win != 2'd2) && (req_win != 2'd3) && be_mode[req_win];
  assign legal   = (req_win != 2'd3) && !(req_win == 2'd2 && req_size);
  assign eff     = req_addr ^ ADDR_W'(swap_en && !req_size);

  always_comb begin
    mod_slot  = '0;
    mod_space = 2'd3;
    mod_ofs   = '0;
    case (req_win)
      2'd0: begin
        mod_slot = eff[9:8];
        case (eff[7:6])
          2'd2:    mod_space = 2'd1;
          2'd3:    mod_space = 2'd2;
          default: mod_space = 2'd0;
        endcase
        mod_ofs = (mod_space == 2'd0) ? OFS_W'(eff[6:0]) : OFS_W'(eff[5:0]);
      end
      2'd1: begin
        mod_slot = eff[MEM16_OFS_W +: 2];
        mod_ofs  = OFS_W'(eff[MEM16_OFS_W-1:0]);
      end
      2'd2: begin
        mod_slot = req_addr[MEM8_OFS_W +: 2];
        mod_ofs  = OFS_W'(req_addr[MEM8_OFS_W-1:0]);
      end
      default: ;
    endcase
  end

  assign mod_stb   = req_valid && legal && slot_present[mod_slot];
  assign mod_write = req_write;
  assign mod_wdata = (swap_en && req_size) ? {req_wdata[7:0], req_wdata[15:8]} : req_wdata;

  always_comb begin
    if (!mod_stb)      rd_next = 16'h0000;
    else if (!req_size) rd_next = {8'h00, mod_rdata[7:0]};
    else if (swap_en)  rd_next = {mod_rdata[7:0], mod_rdata[15:8]};
    else               rd_next = mod_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 16'h0000;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_next;
    end
  end

  assert_resv_win_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_win == 2'd3) |-> !mod_stb);
  assert_id_int_ofs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_stb && req_win == 2'd0 && mod_space != 2'd0) |-> (mod_ofs < OFS_W'(64)));
  assert_byte_only_mem8_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_stb && req_win == 2'd2) |-> !req_size);
  assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !slot_present[mod_slot]) |=> (rsp_rdata == 16'h0000));
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_no_rsp_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  assert_byte_read_hi_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_size) |=> (rsp_rdata[15:8] == 8'h00));

endmodule

// File: tb/carrier_win_decode_tb.sv
module carrier_win_decode_tb;
  localparam int M16 = 4;
  localparam int M8  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_win = '0;
  logic [9:0]  req_addr = '0;
  logic        req_size = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  be_mode = '0;
  logic [3:0]  slot_present = 4'b1011;
  logic [15:0] mod_rdata;
  logic        mod_stb, mod_write, rsp_valid;
  logic [1:0]  mod_slot, mod_space;
  logic [6:0]  mod_ofs;
  logic [15:0] mod_wdata, rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign mod_rdata = {4'hC, mod_slot, mod_space, 1'b0, mod_ofs};

  carrier_win_decode #(.MEM16_OFS_W(M16), .MEM8_OFS_W(M8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .be_mode(be_mode), .slot_present(slot_present),
    .mod_rdata(mod_rdata), .mod_stb(mod_stb), .mod_write(mod_write),
    .mod_slot(mod_slot), .mod_space(mod_space), .mod_ofs(mod_ofs),
    .mod_wdata(mod_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h win=%0d addr=%0h size=%0d wr=%0d be=%0b",
               tag, act, exp, req_win, req_addr, req_size, req_write, be_mode);
    end
  endtask

  task automatic access(input int win, input int addr, input int size, input int wr, input int be);
    logic [9:0]  ea;
    logic [1:0]  slot, space;
    logic [6:0]  ofs;
    logic        sw, legal, stb;
    logic [15:0] wd, rd, exp_rsp;
    @(negedge clk);
    req_valid = 1'b1; req_win = 2'(win); req_addr = 10'(addr);
    req_size = size[0]; req_write = wr[0]; be_mode = 3'(be);
    wd = 16'h5A00 ^ 16'(addr * 7);
    req_wdata = wd;
    sw = (win < 2) && be[win];
    ea = 10'(addr) ^ 10'(sw && size == 0);
    slot = 2'd0; space = 2'd3; ofs = 7'd0;
    if (win == 0) begin
      slot = ea[9:8];
      space = (ea[7:6] == 2) ? 2'd1 : (ea[7:6] == 3) ? 2'd2 : 2'd0;
      ofs = (space == 0) ? ea[6:0] : {1'b0, ea[5:0]};
    end else if (win == 1) begin
      slot = 2'((ea >> M16) & 3);
      ofs = 7'(ea % (1 << M16));
    end else if (win == 2) begin
      slot = 2'((addr >> M8) & 3);
      ofs = 7'(addr % (1 << M8));
    end
    legal = (win != 3) && !(win == 2 && size == 1);
    stb = legal && slot_present[slot];
    #2;
    if (win == 3)                  check("R1 strobe", 32'(mod_stb), 32'(stb));
    else if (win == 2 && size == 1) check("R5 strobe", 32'(mod_stb), 32'(stb));
    else if (!slot_present[slot])   check("R8 strobe", 32'(mod_stb), 32'(stb));
    else                            check("R9 strobe", 32'(mod_stb), 32'(stb));
    if (stb) begin
      if (win == 0) begin
        check(sw && size == 0 ? "R6 slot" : "R2 slot", 32'(mod_slot), 32'(slot));
        check("R2 space", 32'(mod_space), 32'(space));
        check(sw && size == 0 ? "R6 offset" : "R3 offset", 32'(mod_ofs), 32'(ofs));
      end else begin
        check(win == 1 ? "R4 slot" : "R5 slot", 32'(mod_slot), 32'(slot));
        check(win == 1 ? "R4 offset" : "R5 offset", 32'(mod_ofs), 32'(ofs));
        check("R4 space", 32'(mod_space), 32'd3);
      end
      if (wr != 0)
        check("R7 wdata", 32'(mod_wdata), 32'((sw && size == 1) ? {wd[7:0], wd[15:8]} : wd));
    end
    rd = {4'hC, slot, space, 1'b0, ofs};
    if (!stb)          exp_rsp = 16'h0;
    else if (size == 0) exp_rsp = {8'h0, rd[7:0]};
    else if (sw)       exp_rsp = {rd[7:0], rd[15:8]};
    else               exp_rsp = rd;
    @(posedge clk);
    #2;
    be_mode = ~be_mode;
    req_valid = 1'b0;
    #1;
    check("R9 rsp_valid", 32'(rsp_valid), 32'(wr == 0));
    if (wr == 0) begin
      if (!stb)           check("R8 rdata", 32'(rsp_rdata), 32'(exp_rsp));
      else if (size == 0) check("R11 rdata", 32'(rsp_rdata), 32'(exp_rsp));
      else                check("R10 R7 rdata", 32'(rsp_rdata), 32'(exp_rsp));
    end
  endtask

  initial begin
    #3;
    check("R12 reset valid", 32'(rsp_valid), 32'd0);
    check("R12 reset data", 32'(rsp_rdata), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle valid", 32'(rsp_valid), 32'd0);
    check("R12 idle data", 32'(rsp_rdata), 32'd0);
    for (int be = 0; be < 8; be++)
      for (int win = 0; win < 4; win++) begin
        int span;
        span = (win == 0) ? 1024 : (win == 1) ? (4 << M16) : (win == 2) ? (4 << M8) : 16;
        for (int a = 0; a < span; a++)
          for (int sz = 0; sz < 2; sz++)
            for (int wr = 0; wr < 2; wr++)
              access(win, a, sz, wr, be);
      end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule